// File: doc/BRIEF.md
# Load-Use Hazard Stall Unit

This block sits in the decode stage of a five-stage in-order pipeline. It spots the one data dependence that result bypassing cannot cover. A load is in execute, and the instruction right behind it in decode needs the loaded register as an ALU operand. The loaded value only appears at the end of the memory stage, so the dependent instruction must wait one cycle.

When that case occurs, the unit asserts three control lines in the same cycle. One holds the program counter, one holds the fetch/decode latch, and one tells the decode/execute latch to capture a bubble in place of the decoded instruction. One cycle later the load has moved on to the memory stage, and the dependent instruction gets its operand from the bypass network. A store that uses the loaded register only as the data it writes is not held, because the memory stage bypasses that value.

Register 0 is a constant and never causes a hold. A source register only counts when its use flag says decode actually reads it. A small state bit ensures that a hold never lasts longer than one cycle.

Top module: `hz_load_use_stall`

## Requirements
- R1: While rst_n is low, pc_hold, ifid_hold and idex_bubble are all 0.
- R2: With ex_is_load=1, ex_dst not 0, dec_use_a=1 and dec_src_a equal to ex_dst, the hold outputs are 1 in the same cycle, provided no hold was asserted in the previous cycle.
- R3: With ex_is_load=1, ex_dst not 0, dec_use_b=1, dec_b_store_only=0 and dec_src_b equal to ex_dst, the hold outputs are 1 in the same cycle, provided no hold was asserted in the previous cycle.
- R4: Suppose operand b matches ex_dst, dec_b_store_only=1, and operand a does not match. Then no hold is raised.
- R5: When ex_dst is register 0, no hold is raised, whatever the source registers are.
- R6: A source that equals ex_dst but whose use flag (dec_use_a or dec_use_b) is 0 raises no hold.
- R7: When ex_is_load=0, no hold is raised.
- R8: A hold lasts exactly one cycle. In the cycle after a hold, all outputs are 0 even if the hazard inputs are unchanged.
- R9: pc_hold, ifid_hold and idex_bubble always carry the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pipeline clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_src_a | input | REG_AW | First source register of the decode instruction |
| dec_src_b | input | REG_AW | Second source register of the decode instruction |
| dec_use_a | input | 1 | Decode instruction reads dec_src_a |
| dec_use_b | input | 1 | Decode instruction reads dec_src_b |
| dec_b_store_only | input | 1 | dec_src_b is used only as store data |
| ex_is_load | input | 1 | Execute-stage instruction is a load |
| ex_dst | input | REG_AW | Destination register of the execute-stage instruction |
| pc_hold | output | 1 | Keep the program counter unchanged this cycle |
| ifid_hold | output | 1 | Keep the fetch/decode latch unchanged this cycle |
| idex_bubble | output | 1 | Load a no-op into the decode/execute latch |

## Verification
The hardest situation to reach from the ports is a hazard that stays present in the inputs for several cycles. In a real pipeline the bubble removes it after one cycle, so it only arises when a stimulus keeps the load in execute on purpose. The bench holds one matching load/consumer pair steady over three cycles and expects the outputs to alternate on, off, on. It also raises reset in the middle of a live hazard, to show that reset overrides the match.

// File: rtl/hz_pkg.sv
package hz_pkg;
   localparam int NUM_DEC_SRC = 2;

   typedef enum logic {
      ROLE_ALU        = 1'b0,
      ROLE_STORE_DATA = 1'b1
   } src_role_e;
endpackage

// File: rtl/hz_src_cmp.sv
module hz_src_cmp #(
   parameter int REG_AW            = 5,
   parameter bit STORE_DATA_BYPASS = 1'b1
) (
   input  logic [REG_AW-1:0] src_idx,
   input  logic              src_use,
   input  hz_pkg::src_role_e src_role,
   input  logic              load_live,
   input  logic [REG_AW-1:0] load_dst,
   output logic              hit
);
   logic needs_in_ex;

   generate
      if (STORE_DATA_BYPASS) begin : g_bypass
         assign needs_in_ex = (src_role == hz_pkg::ROLE_ALU);
      end else begin : g_no_bypass
         logic unused_role;
         assign unused_role = (src_role == hz_pkg::ROLE_ALU);
         assign needs_in_ex = 1'b1;
      end
   endgenerate

   assign hit = load_live && src_use && needs_in_ex && (src_idx == load_dst);
endmodule

// File: rtl/hz_stall_seq.sv
module hz_stall_seq (
   input  logic clk,
   input  logic rst_n,
   input  logic hazard,
   output logic stall
);
   logic stalled_q;

   assign stall = rst_n && hazard && !stalled_q;

   always_ff @(posedge clk) begin
      if (!rst_n) stalled_q <= 1'b0;
      else        stalled_q <= stall;
   end
endmodule

// File: rtl/hz_load_use_stall.sv
module hz_load_use_stall #(
   parameter int REG_AW            = 5,
   parameter bit ZERO_REG_CONST    = 1'b1,
   parameter bit STORE_DATA_BYPASS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [REG_AW-1:0] dec_src_a,
   input  logic [REG_AW-1:0] dec_src_b,
   input  logic              dec_use_a,
   input  logic              dec_use_b,
   input  logic              dec_b_store_only,
   input  logic              ex_is_load,
   input  logic [REG_AW-1:0] ex_dst,
   output logic              pc_hold,
   output logic              ifid_hold,
   output logic              idex_bubble
);
   localparam int NSRC = hz_pkg::NUM_DEC_SRC;

   generate
      if (REG_AW < 2 || REG_AW > 8) begin : g_bad_aw
         $error("hz_load_use_stall: REG_AW out of range");
      end
      if (NSRC != 2) begin : g_bad_nsrc
         $error("hz_load_use_stall: two decode sources expected");
      end
   endgenerate

   logic [NSRC-1:0][REG_AW-1:0] src_idx;
   logic [NSRC-1:0]             src_use;
   hz_pkg::src_role_e           src_role [NSRC];
   logic [NSRC-1:0]             src_hit;
   logic                        load_live;
   logic                        stall;

   always_comb begin
      src_idx[0]  = dec_src_a;
      src_idx[1]  = dec_src_b;
      src_use[0]  = dec_use_a;
      src_use[1]  = dec_use_b;
      src_role[0] = hz_pkg::ROLE_ALU;
      src_role[1] = dec_b_store_only ? hz_pkg::ROLE_STORE_DATA : hz_pkg::ROLE_ALU;
   end

   generate
      if (ZERO_REG_CONST) begin : g_zero_const
         assign load_live = ex_is_load && (ex_dst != '0);
      end else begin : g_zero_plain
         assign load_live = ex_is_load;
      end

      for (genvar i = 0; i < NSRC; i++) begin : g_src
         hz_src_cmp #(
            .REG_AW           (REG_AW),
            .STORE_DATA_BYPASS(STORE_DATA_BYPASS)
         ) u_cmp (
            .src_idx  (src_idx[i]),
            .src_use  (src_use[i]),
            .src_role (src_role[i]),
            .load_live(load_live),
            .load_dst (ex_dst),
            .hit      (src_hit[i])
         );
      end
   endgenerate

   hz_stall_seq u_seq (
      .clk   (clk),
      .rst_n (rst_n),
      .hazard(|src_hit),
      .stall (stall)
   );

   assign pc_hold     = stall;
   assign ifid_hold   = stall;
   assign idex_bubble = stall;
endmodule

// File: rtl/hz_stall_chk.sv
module hz_stall_chk #(
   parameter int REG_AW = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic [REG_AW-1:0] dec_src_a,
   input logic [REG_AW-1:0] dec_src_b,
   input logic              dec_use_a,
   input logic              dec_use_b,
   input logic              dec_b_store_only,
   input logic              ex_is_load,
   input logic [REG_AW-1:0] ex_dst,
   input logic              pc_hold,
   input logic              ifid_hold,
   input logic              idex_bubble
);
   p_reset_quiet_r1: assert property (@(posedge clk)
      !rst_n |-> !(pc_hold || ifid_hold || idex_bubble));

   p_src_a_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (ex_is_load && ex_dst != '0 && dec_use_a && dec_src_a == ex_dst && !$past(pc_hold))
      |-> pc_hold);

   p_store_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_b_store_only && !(dec_use_a && dec_src_a == ex_dst)) |-> !pc_hold);

   p_zero_dst_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ex_dst == '0) |-> !pc_hold);

   p_no_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !ex_is_load |-> !pc_hold);

   p_one_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      pc_hold |=> !pc_hold);

   p_lines_agree_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (pc_hold == ifid_hold) && (ifid_hold == idex_bubble));
endmodule

bind hz_load_use_stall hz_stall_chk #(.REG_AW(REG_AW)) u_chk (.*);

// File: tb/sim_hz_load_use_stall.sv
module sim_hz_load_use_stall;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 5;
   localparam int NV = 11;

   // fields: src_a[23:19] src_b[18:14] use_a[13] use_b[12] st_only[11] ld[10] dst[9:5] exp[4] req[3:0]
   localparam logic [23:0] VEC [NV] = '{
      {5'd3,  5'd7,  1'b1, 1'b1, 1'b0, 1'b1, 5'd3,  1'b1, 4'd2}, // R2 basic a match
      {5'd9,  5'd3,  1'b1, 1'b1, 1'b0, 1'b1, 5'd3,  1'b1, 4'd3}, // R3 b match as ALU operand
      {5'd31, 5'd31, 1'b1, 1'b0, 1'b0, 1'b1, 5'd31, 1'b1, 4'd2}, // R2 top register index
      {5'd2,  5'd5,  1'b1, 1'b1, 1'b1, 1'b1, 5'd5,  1'b0, 4'd4}, // R4 store data only
      {5'd5,  5'd5,  1'b1, 1'b1, 1'b1, 1'b1, 5'd5,  1'b1, 4'd2}, // R2 a still matches with store
      {5'd0,  5'd0,  1'b1, 1'b1, 1'b0, 1'b1, 5'd0,  1'b0, 4'd5}, // R5 register 0
      {5'd4,  5'd6,  1'b0, 1'b1, 1'b0, 1'b1, 5'd4,  1'b0, 4'd6}, // R6 a unused
      {5'd4,  5'd6,  1'b1, 1'b0, 1'b0, 1'b1, 5'd6,  1'b0, 4'd6}, // R6 b unused
      {5'd4,  5'd4,  1'b1, 1'b1, 1'b0, 1'b0, 5'd4,  1'b0, 4'd7}, // R7 producer not a load
      {5'd8,  5'd1,  1'b1, 1'b1, 1'b0, 1'b1, 5'd2,  1'b0, 4'd2}, // R2 no match
      {5'd6,  5'd12, 1'b1, 1'b1, 1'b0, 1'b1, 5'd12, 1'b1, 4'd3}  // R3 b match second pattern
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] dec_src_a = '0, dec_src_b = '0, ex_dst = '0;
   logic          dec_use_a = 1'b0, dec_use_b = 1'b0, dec_b_store_only = 1'b0, ex_is_load = 1'b0;
   logic          pc_hold, ifid_hold, idex_bubble;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   hz_load_use_stall #(.REG_AW(AW)) u0 (
      .clk(clk), .rst_n(rst_n),
      .dec_src_a(dec_src_a), .dec_src_b(dec_src_b),
      .dec_use_a(dec_use_a), .dec_use_b(dec_use_b),
      .dec_b_store_only(dec_b_store_only),
      .ex_is_load(ex_is_load), .ex_dst(ex_dst),
      .pc_hold(pc_hold), .ifid_hold(ifid_hold), .idex_bubble(idex_bubble)
   );

   task automatic check(input string req, input logic exp);
      checks++;
      if (pc_hold !== exp || ifid_hold !== exp || idex_bubble !== exp) begin
         failures++;
         $display("FAIL %s: pc_hold=%b ifid_hold=%b idex_bubble=%b expected %b",
                  req, pc_hold, ifid_hold, idex_bubble, exp);
      end
   endtask

   task automatic drive(input logic [23:0] v);
      dec_src_a        = v[23:19];
      dec_src_b        = v[18:14];
      dec_use_a        = v[13];
      dec_use_b        = v[12];
      dec_b_store_only = v[11];
      ex_is_load       = v[10];
      ex_dst           = v[9:5];
   endtask

   task automatic idle();
      drive(24'd0);
   endtask

   initial begin
      // R1: reset with a live hazard on the inputs
      drive({5'd3, 5'd0, 1'b1, 1'b0, 1'b0, 1'b1, 5'd3, 1'b0, 4'd0});
      repeat (2) @(negedge clk);
      #1 check("R1 reset with hazard present", 1'b0);
      @(negedge clk);
      rst_n = 1'b1;
      idle();
      #1 check("R1 idle after reset", 1'b0);

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         drive(VEC[i]);
         #1 check($sformatf("R%0d vector %0d (R9 lines agree)", VEC[i][3:0], i), VEC[i][4]);
         @(negedge clk);
         idle();
      end

      // R8: hazard held steady -> on, off, on
      @(negedge clk);
      drive({5'd10, 5'd0, 1'b1, 1'b0, 1'b0, 1'b1, 5'd10, 1'b0, 4'd0});
      #1 check("R8 held hazard first cycle", 1'b1);
      @(negedge clk);
      #1 check("R8 held hazard second cycle", 1'b0);
      @(negedge clk);
      #1 check("R8 held hazard third cycle", 1'b1);

      // R8: a different hazard right after a hold is also masked
      @(negedge clk);
      drive({5'd0, 5'd11, 1'b0, 1'b1, 1'b0, 1'b1, 5'd11, 1'b0, 4'd0});
      #1 check("R8 new hazard after hold", 1'b0);
      @(negedge clk);
      #1 check("R3 new hazard one cycle later", 1'b1);

      // R1: reset in the middle of a live hazard
      @(negedge clk);
      idle();
      @(negedge clk);
      drive({5'd14, 5'd0, 1'b1, 1'b0, 1'b0, 1'b1, 5'd14, 1'b0, 4'd0});
      rst_n = 1'b0;
      #1 check("R1 reset mid-hazard", 1'b0);
      @(negedge clk);
      rst_n = 1'b1;
      #1 check("R2 hazard after reset release", 1'b1);

      @(negedge clk);
      idle();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (2000) @(posedge clk);
            failures++;
            $display("FAIL watchdog: expected completion, actual timeout");
         end
      join_any
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule